// File: doc/BRIEF.md
# Processor-Memory Completion-Handshake Bridge

This block connects a simple processor core to a word-organized memory whose access time is not fixed. The core issues one request at a time as a start pulse carrying a direction, a byte/word size flag, an address and write data. The bridge captures the address into its own address register and, for writes, the data into its own data register. It then drives a Read or a Write strobe toward the memory. It holds that strobe until the memory answers with a completion acknowledge, which may come after any number of cycles.

Accesses are made to 32-bit words and are byte-addressable. The low two address bits choose a byte lane, and a byte-size line tells the memory that only one lane is involved. On a byte read, the chosen lane comes back zero-extended. On a byte write, only the chosen lane is enabled.

A busy flag keeps out overlapping requests. A new request is accepted only after the memory has dropped its acknowledge again. If the acknowledge never comes, a cycle counter ends the transfer with an error pulse instead of letting the bridge hang.

Top module: `mfc_bridge`

## Requirements
- R1: After reset, `req_busy`, `req_done`, `req_err`, `mem_rd` and `mem_wr` are all 0.
- R2: A `req_start` seen at a clock edge while idle and while `mem_mfc` is low is accepted. In the next cycle `req_busy` is 1, `mem_addr` equals the requested address, and the strobe for the requested direction (`mem_rd` when `req_write`=0, `mem_wr` when `req_write`=1) is 1.
- R3: A word read holds `mem_rd` high until `mem_mfc` is sampled high. In the following cycle `mem_rd` is 0, `req_done` is 1, and `req_rdata` equals the `mem_rdata` value sampled with the acknowledge.
- R4: A word write presents the request data on `mem_wdata` while `mem_wr` is high. It holds `mem_wr` until `mem_mfc` is sampled high, then drops it and pulses `req_done` in the next cycle.
- R5: A byte read (`req_byte`=1) returns lane n of the acknowledged word in `req_rdata[7:0]`, with bits 31:8 zero. Lane n is `mem_rdata[8n+7:8n]` and n is address bits 1:0.
- R6: During a byte access `mem_byte` is 1 and `mem_lane_en` has only bit n set. A byte write places `req_wdata[7:0]` on lane n of `mem_wdata`, with the other lanes zero. During a word access `mem_byte` is 0 and `mem_lane_en` is 4'b1111.
- R7: A `req_start` that arrives while `req_busy` is 1 is ignored. `mem_addr` keeps the accepted address and no extra transfer starts.
- R8: After completion, `req_busy` stays 1 and no request is accepted while `mem_mfc` remains high. `req_busy` returns to 0 in the cycle after `mem_mfc` is sampled low.
- R9: If `mem_mfc` has not been seen after the strobe has been high for TIMEOUT cycles, the strobe drops and `req_done` and `req_err` pulse together in the next cycle.
- R10: `req_done` and `req_err` are single-cycle pulses, and `req_err` is 0 on a transfer that ends with an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request pulse from the core |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = single-byte transfer, 0 = full word |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data (byte in bits 7:0 for byte writes) |
| req_busy | output | 1 | Transfer in progress or waiting for acknowledge release |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | One-cycle timeout pulse, coincident with done |
| req_rdata | output | DATA_W | Read result, valid with done |
| mem_addr | output | ADDR_W | Address register contents |
| mem_wdata | output | DATA_W | Data register contents toward memory |
| mem_rdata | input | DATA_W | Data from memory, taken with the acknowledge |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_byte | output | 1 | Byte-transfer indicator |
| mem_lane_en | output | DATA_W/8 | Byte-lane enables |
| mem_mfc | input | 1 | Memory completion acknowledge |

## Verification
A start accepted at one edge shows its strobe, address and lane enables one cycle later. The strobe stays high for as many cycles as the acknowledge is delayed. The done pulse and read data appear in the cycle after the acknowledge is sampled. `req_busy` falls in the cycle after the acknowledge is seen low. For a timeout, done and error pulse after exactly TIMEOUT strobe cycles. The bench drives every input on the falling edge and samples on the falling edge. It walks each transfer one cycle at a time and compares every observed strobe, busy, done and data value against what it computed for that cycle. It counts the strobe cycles itself, so latency and timeout windows are checked by cycle rather than by eventual outcome.

// File: rtl/mfc_bridge.sv
module mfc_bridge #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int TIMEOUT = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_start,
  input  logic                req_write,
  input  logic                req_byte,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_busy,
  output logic                req_done,
  output logic                req_err,
  output logic [DATA_W-1:0]   req_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                mem_byte,
  output logic [DATA_W/8-1:0] mem_lane_en,
  input  logic                mem_mfc
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int CNT_W  = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_REL} st_t;

  st_t               st;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mdr;
  logic              op_wr, op_byte, done_q, err_q;
  logic [CNT_W-1:0]  cnt;

  wire [LANE_W-1:0] lane     = mar[LANE_W-1:0];
  wire [LANE_W-1:0] req_lane = req_addr[LANE_W-1:0];
  wire              accept   = (st == S_IDLE) && req_start && !mem_mfc;
  wire              in_acc   = (st == S_ACC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; mar <= '0; mdr <= '0; op_wr <= 1'b0; op_byte <= 1'b0;
      cnt <= '0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          mar     <= req_addr;
          op_wr   <= req_write;
          op_byte <= req_byte;
          cnt     <= '0;
          if (req_write)
            mdr <= req_byte ? (DATA_W'(req_wdata[7:0]) << {req_lane, 3'b000}) : req_wdata;
          st <= S_ACC;
        end
        S_ACC: begin
          if (mem_mfc) begin
            if (!op_wr)
              mdr <= op_byte ? DATA_W'(mem_rdata[{lane, 3'b000} +: 8]) : mem_rdata;
            done_q <= 1'b1;
            st     <= S_REL;
          end else if (cnt == CNT_W'(TIMEOUT - 1)) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            st     <= S_REL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REL: if (!mem_mfc) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_busy    = (st != S_IDLE);
  assign req_done    = done_q;
  assign req_err     = err_q;
  assign req_rdata   = mdr;
  assign mem_addr    = mar;
  assign mem_wdata   = mdr;
  assign mem_rd      = in_acc && !op_wr;
  assign mem_wr      = in_acc && op_wr;
  assign mem_byte    = in_acc && op_byte;
  assign mem_lane_en = op_byte ? (LANES'(1) << lane) : {LANES{1'b1}};

  // strobe run-length watcher for the timeout window
  logic [CNT_W-1:0] strobe_run;
  always_ff @(posedge clk) begin
    if (!rst_n) strobe_run <= '0;
    else if (mem_rd || mem_wr) strobe_run <= strobe_run + 1'b1;
    else strobe_run <= '0;
  end

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_strobe_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && mem_mfc) |=> (!mem_rd && !mem_wr && req_done && !req_err));
  assert_lane_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_byte |-> ($countones(mem_lane_en) == 1));
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_busy |=> $stable(mem_addr));
  assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_busy && mem_mfc) |=> !req_busy);
  assert_timeout_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (strobe_run < CNT_W'(TIMEOUT)));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);
  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> req_done);
endmodule

// File: tb/mfc_bridge_bench.sv
module mfc_bridge_bench;
  localparam int TO = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_start = 0, req_write = 0, req_byte = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, mem_rdata = 0;
  logic mem_mfc = 0;
  logic req_busy, req_done, req_err, mem_rd, mem_wr, mem_byte;
  logic [31:0] req_rdata, mem_addr, mem_wdata;
  logic [3:0] mem_lane_en;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mfc_bridge #(.ADDR_W(32), .DATA_W(32), .TIMEOUT(TO)) u_mfc_bridge (
    .clk, .rst_n, .req_start, .req_write, .req_byte, .req_addr, .req_wdata,
    .req_busy, .req_done, .req_err, .req_rdata, .mem_addr, .mem_wdata,
    .mem_rdata, .mem_rd, .mem_wr, .mem_byte, .mem_lane_en, .mem_mfc);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input bit wr, input bit by, input logic [31:0] addr,
                    input logic [31:0] wd, input logic [31:0] rword,
                    input int lat, input int hold, input bit poke);
    logic [31:0] exp_wd, exp_rd;
    logic [3:0]  exp_lane;
    exp_wd   = by ? ({24'h0, wd[7:0]} << (8 * addr[1:0])) : wd;
    exp_rd   = by ? ((rword >> (8 * addr[1:0])) & 32'hFF) : rword;
    exp_lane = by ? (4'b0001 << addr[1:0]) : 4'b1111;
    @(negedge clk);
    req_start = 1; req_write = wr; req_byte = by; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_start = 0;
    chk("R2 busy", req_busy, 1);
    chk("R2 addr", mem_addr, addr);
    chk("R2 strobe", {mem_rd, mem_wr}, wr ? 2'b01 : 2'b10);
    chk("R6 lanes", mem_lane_en, exp_lane);
    chk("R6 byte", mem_byte, by);
    if (wr) chk("R4 wdata", mem_wdata, exp_wd);
    for (int i = 2; i <= lat; i++) begin
      if (poke && i == 2) begin
        req_start = 1; req_addr = ~addr; req_write = ~wr;
      end
      @(negedge clk);
      req_start = 0;
      chk(wr ? "R4 hold" : "R3 hold", {mem_rd, mem_wr}, wr ? 2'b01 : 2'b10);
      if (poke) chk("R7 addr kept", mem_addr, addr);
    end
    mem_mfc = 1; mem_rdata = rword;
    @(negedge clk);
    mem_rdata = 32'hDEAD_BEEF;
    chk(wr ? "R4 drop" : "R3 drop", {mem_rd, mem_wr}, 0);
    chk("R3 done", req_done, 1);
    chk("R10 no err", req_err, 0);
    if (!wr) chk(by ? "R5 byte rdata" : "R3 rdata", req_rdata, exp_rd);
    for (int h = 0; h < hold; h++) begin
      req_start = 1; req_addr = addr ^ 32'h10; req_write = 0;
      @(negedge clk);
      req_start = 0;
      chk("R8 busy held", req_busy, 1);
      chk("R8 no strobe", {mem_rd, mem_wr}, 0);
      chk("R10 pulse", req_done, 0);
    end
    mem_mfc = 0;
    @(negedge clk);
    chk("R8 release", req_busy, 0);
    chk("R8 no new op", {mem_rd, mem_wr}, 0);
  endtask

  task automatic timeout_op(input bit wr);
    int n;
    @(negedge clk);
    req_start = 1; req_write = wr; req_byte = 0; req_addr = 32'h40; req_wdata = 32'h1;
    @(negedge clk);
    req_start = 0;
    n = 0;
    while ((mem_rd || mem_wr) && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R9 window", n, TO);
    chk("R9 done", req_done, 1);
    chk("R9 err", req_err, 1);
    @(negedge clk);
    chk("R10 err pulse", req_err, 0);
    chk("R9 idle", req_busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", req_busy, 0);
    chk("R1 done", req_done, 0);
    chk("R1 err", req_err, 0);
    chk("R1 strobes", {mem_rd, mem_wr}, 0);
    rst_n = 1;
    op(0, 0, 32'h0000_1000, 0, 32'hCAFE_F00D, 1, 0, 0);
    op(0, 0, 32'h0000_2004, 0, 32'h1234_5678, 5, 2, 1);
    op(1, 0, 32'h0000_3008, 32'hA5A5_5A5A, 0, 3, 1, 0);
    op(1, 0, 32'h0000_300C, 32'h0F0F_F0F0, 0, TO, 0, 1);
    for (int b = 0; b < 4; b++) begin
      op(0, 1, 32'h0000_4000 + b, 0, 32'h8877_6655, 2, 0, 0);
      op(1, 1, 32'h0000_5000 + b, 32'hFFFF_FF00 | (8'h31 + b), 0, 1, 1, 0);
    end
    timeout_op(0);
    timeout_op(1);
    op(0, 0, 32'h0000_6000, 0, 32'h0BAD_C0DE, 4, 3, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule